// File: doc/BRIEF.md
# Power Mode Clock Gating Controller

This block holds the sleep-mode control register of a small microcontroller core and turns its contents into two clock enables. One enable feeds the CPU. The other feeds the peripheral group: the serial port, the converter, the timers and the interrupt logic. There are two levels of sleep. In idle, only the CPU enable drops, so the peripherals keep working and can raise the interrupt that ends the sleep. In power-down, both enables drop and the chip is frozen until an external wake-up request or a reset arrives.

Software writes the register through a simple write strobe and reads it back at any time. Two bits of the register are general-purpose flags that software may use freely. The enables are register outputs and change only on a rising edge of the free-running clock, so a downstream clock gate never sees a partial pulse. Oscillator shutdown and analog settling are outside this block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, every register bit reads 0 and both `cpu_clk_en` and `per_clk_en` are 1.
- R2: A write with bit 0 (idle) set and bit 1 clear makes bit 0 read 1 and drops `cpu_clk_en` to 0 from the edge that takes the write, while `per_clk_en` stays 1.
- R3: A write with bit 1 (power-down) set makes bit 1 read 1 and drops both `cpu_clk_en` and `per_clk_en` to 0 from the edge that takes the write.
- R4: When a single write sets both bit 0 and bit 1, power-down wins: the register reads bit 1 = 1 and bit 0 = 0.
- R5: Bits 3:2 are user flags. They read back exactly what was last written and have no effect on either enable.
- R6: Bits 7:4 always read 0, whatever value is written to them.
- R7: While idle is set, a one-cycle `irq_wake` pulse clears bit 0 and brings `cpu_clk_en` back to 1 at the next rising edge.
- R8: While power-down is set, `irq_wake` has no effect: bit 1 stays 1 and both enables stay 0.
- R9: While either mode bit is set, a one-cycle `ext_wake` pulse clears both mode bits and brings both enables back to 1 at the next rising edge.
- R10: When a register write and a wake input fall on the same edge, the written value is stored and the wake request is discarded.
- R11: With no mode bit set, the wake inputs change neither the register contents nor the enables.
- R12: Bits 0 and 1 never read 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data for the control register |
| reg_rdata | output | 8 | Current register contents |
| irq_wake | input | 1 | Enabled interrupt request from the interrupt logic |
| ext_wake | input | 1 | External wake-up request |
| cpu_clk_en | output | 1 | Clock enable for the CPU |
| per_clk_en | output | 1 | Clock enable for the peripheral group |

## Verification
Every result is due one rising edge after its stimulus. A write or wake input driven before edge k shows on `reg_rdata` and on both enables right after edge k, because the register and the enable flops both load from the same next-state logic. The bench drives inputs on falling edges, holds them for one full cycle and samples on the next falling edge, so each check reads the value produced by exactly one edge. For the no-effect cases (R8, R11), the bench samples both the register and the enables in that same cycle, before any further stimulus.

// File: rtl/pwr_mode_pkg.sv
// Package: pwr_mode_pkg
// Holds the register width and the positions of the fields that the
// rest of the block decodes. Assumes the mode bits sit below the flags.
package pwr_mode_pkg;
    parameter int DATA_W    = 8;
    parameter int IDLE_BIT  = 0;
    parameter int PD_BIT    = 1;
    parameter int FLAG_LSB  = 2;
    parameter int NUM_FLAGS = 2;
    localparam int FLAG_MSB = FLAG_LSB + NUM_FLAGS - 1;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
        logic                 pd;
        logic                 idle;
    } pwr_state_t;
endpackage

// File: rtl/pwr_ctrl_reg.sv
// Module: pwr_ctrl_reg
// Stores the mode bits and user flags and computes their next state from
// writes and wake requests. Assumes wake inputs are already synchronous
// to clk. A write overrides a wake request on the same edge, and
// power-down overrides idle within one write.
module pwr_ctrl_reg
    import pwr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_wake,
    input  logic              ext_wake,
    output pwr_state_t        state_q,
    output pwr_state_t        state_n
);
    logic unused_hi;
    assign unused_hi = ^wdata[DATA_W-1:FLAG_MSB+1];

    // Next-state selection: write first, then external wake, then interrupt wake.
    always_comb begin
        state_n = state_q;
        if (wr_en) begin
            state_n.pd    = wdata[PD_BIT];
            state_n.idle  = wdata[IDLE_BIT] & ~wdata[PD_BIT];
            state_n.flags = wdata[FLAG_MSB:FLAG_LSB];
        end else if (ext_wake) begin
            state_n.pd   = 1'b0;
            state_n.idle = 1'b0;
        end else if (irq_wake && !state_q.pd) begin
            state_n.idle = 1'b0;
        end
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_n;
    end
endmodule

// File: rtl/pwr_clk_gate.sv
// Module: pwr_clk_gate
// Registers the CPU and peripheral clock enables from the next mode
// state, so each enable is a plain flop that moves only on a rising
// edge. Both enables are high out of reset.
module pwr_clk_gate
    import pwr_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_t state_n,
    output logic       cpu_en,
    output logic       per_en
);
    // Enable flops: CPU stops in either mode, peripherals only in power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_en <= 1'b1;
            per_en <= 1'b1;
        end else begin
            cpu_en <= ~(state_n.idle | state_n.pd);
            per_en <= ~state_n.pd;
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl
// Top of the power-mode controller: control register plus clock-enable
// generation, with the read-back value assembled from the stored fields.
// Assumes a single synchronous clock domain and an active-low sync reset.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              irq_wake,
    input  logic              ext_wake,
    output logic              cpu_clk_en,
    output logic              per_clk_en
);
    pwr_state_t st_q;
    pwr_state_t st_n;

    pwr_ctrl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wdata    (reg_wdata),
        .irq_wake (irq_wake),
        .ext_wake (ext_wake),
        .state_q  (st_q),
        .state_n  (st_n)
    );

    pwr_clk_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_n (st_n),
        .cpu_en  (cpu_clk_en),
        .per_en  (per_clk_en)
    );

    // Read-back bits: one per register position, reserved ones tied low.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rd
        if (i == IDLE_BIT) begin : g_idle
            assign reg_rdata[i] = st_q.idle;
        end else if (i == PD_BIT) begin : g_pd
            assign reg_rdata[i] = st_q.pd;
        end else if (i >= FLAG_LSB && i <= FLAG_MSB) begin : g_flag
            assign reg_rdata[i] = st_q.flags[i-FLAG_LSB];
        end else begin : g_resv
            assign reg_rdata[i] = 1'b0;
        end
    end
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
// Module: pwr_mode_ctrl_chk
// Property checker for pwr_mode_ctrl, attached through bind. Watches only
// the ports of the top module.
module pwr_mode_ctrl_chk
    import pwr_mode_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq_wake,
    input logic              ext_wake,
    input logic              cpu_clk_en,
    input logic              per_clk_en
);
    AST_RESET_RUN: assert property (@(posedge clk) $rose(rst_n) |-> cpu_clk_en && per_clk_en && reg_rdata == '0); // R1
    AST_IDLE_CPU_OFF: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[IDLE_BIT] |-> !cpu_clk_en && per_clk_en); // R2
    AST_PD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[PD_BIT] |-> !cpu_clk_en && !per_clk_en); // R3
    AST_BOTH_PD_WINS: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr_en && reg_wdata[PD_BIT] && reg_wdata[IDLE_BIT]) |=> reg_rdata[PD_BIT] && !reg_rdata[IDLE_BIT]); // R4
    AST_FLAGS_STORE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr_en |=> reg_rdata[FLAG_MSB:FLAG_LSB] == $past(reg_wdata[FLAG_MSB:FLAG_LSB])); // R5
    AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[DATA_W-1:FLAG_MSB+1] == '0); // R6
    AST_IRQ_WAKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (reg_rdata[IDLE_BIT] && irq_wake && !reg_wr_en) |=> cpu_clk_en && !reg_rdata[IDLE_BIT]); // R7
    AST_IRQ_KEEP_PD: assert property (@(posedge clk) disable iff (!rst_n) (reg_rdata[PD_BIT] && !ext_wake && !reg_wr_en) |=> reg_rdata[PD_BIT] && !per_clk_en); // R8
    AST_EXT_WAKE_ALL: assert property (@(posedge clk) disable iff (!rst_n) (ext_wake && !reg_wr_en) |=> cpu_clk_en && per_clk_en); // R9
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n) (reg_wr_en && reg_wdata[PD_BIT]) |=> !per_clk_en); // R10
    AST_IDLE_WAKE_NOP: assert property (@(posedge clk) disable iff (!rst_n) (reg_rdata[PD_BIT:IDLE_BIT] == 2'b00 && !reg_wr_en) |=> $stable(reg_rdata)); // R11
    AST_MODES_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_rdata[IDLE_BIT] && reg_rdata[PD_BIT])); // R12
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_wake   (irq_wake),
    .ext_wake   (ext_wake),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
// Bench: directed scenarios for pwr_mode_ctrl, one task each, 50 MHz clock.
// Inputs move on falling edges; results are sampled one falling edge later.
module pwr_mode_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_wake = 1'b0;
    logic       ext_wake = 1'b0;
    logic       cpu_clk_en;
    logic       per_clk_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_mode_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr_en  (reg_wr_en),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_wake   (irq_wake),
        .ext_wake   (ext_wake),
        .cpu_clk_en (cpu_clk_en),
        .per_clk_en (per_clk_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Checks register, CPU enable and peripheral enable together.
    task automatic chk_all(input string req, input logic [7:0] rd, input logic cpu, input logic per);
        chk({req, " rdata"}, reg_rdata, rd);
        chk({req, " cpu_en"}, {7'd0, cpu_clk_en}, {7'd0, cpu});
        chk({req, " per_en"}, {7'd0, per_clk_en}, {7'd0, per});
    endtask

    // One cycle of stimulus: drive on a falling edge, release on the next.
    task automatic cyc(input logic wr, input logic [7:0] d, input logic irq, input logic ext);
        reg_wr_en = wr; reg_wdata = d; irq_wake = irq; ext_wake = ext;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = 8'h00; irq_wake = 1'b0; ext_wake = 1'b0;
    endtask

    task automatic t_reset();
        chk_all("R1 reset", 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_idle();
        cyc(1'b1, 8'h01, 1'b0, 1'b0);
        chk_all("R2 idle", 8'h01, 1'b0, 1'b1);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk_all("R7 irq wake", 8'h00, 1'b1, 1'b1);
        cyc(1'b1, 8'h01, 1'b0, 1'b0);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk_all("R9 ext wake from idle", 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_pdown();
        cyc(1'b1, 8'h02, 1'b0, 1'b0);
        chk_all("R3 power-down", 8'h02, 1'b0, 1'b0);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk_all("R8 irq ignored", 8'h02, 1'b0, 1'b0);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk_all("R9 ext wake from pd", 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_both();
        cyc(1'b1, 8'h03, 1'b0, 1'b0);
        chk_all("R4 both set", 8'h02, 1'b0, 1'b0);
        chk("R12 exclusive", {6'd0, reg_rdata[1:0]}, 8'h02);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk_all("R9 clear after both", 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_flags();
        cyc(1'b1, 8'hFC, 1'b0, 1'b0);
        chk_all("R5 R6 flags high", 8'h0C, 1'b1, 1'b1);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        chk_all("R11 irq no mode", 8'h0C, 1'b1, 1'b1);
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
        chk_all("R11 ext no mode", 8'h0C, 1'b1, 1'b1);
        cyc(1'b1, 8'hB4, 1'b0, 1'b0);
        chk_all("R5 R6 flag pattern", 8'h04, 1'b1, 1'b1);
    endtask

    task automatic t_race();
        cyc(1'b1, 8'h02, 1'b0, 1'b0);
        cyc(1'b1, 8'h09, 1'b1, 1'b1);
        chk_all("R10 write beats wake", 8'h09, 1'b0, 1'b1);
        cyc(1'b1, 8'h02, 1'b0, 1'b1);
        chk_all("R10 write pd with ext", 8'h02, 1'b0, 1'b0);
        cyc(1'b1, 8'h00, 1'b0, 1'b0);
        chk_all("R10 release", 8'h00, 1'b1, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_pdown();
        t_both();
        t_flags();
        t_race();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule